// File: doc/BRIEF.md
# CAN bus-off recovery monitor

This block watches the sampled bit stream of a CAN node while that node is bus-off, and decides when recovery may complete. Each bit-sample strobe delivers one received bit, with recessive coded as 1. The block counts separate runs of consecutive recessive bits. Once a set number of such runs has been seen, it issues a recovery-done pulse. In the same cycle it tells the error-counter logic to clear both the transmit and the receive counters, and tells the mode logic to return to Normal operation.

Counting is armed in one of two ways. The automatic-recovery enable can be held at 1, or the host can strobe a recovery request while the node is bus-off. The enable defaults to 0, which leaves recovery in the host's hands. A host request stays latched until recovery completes or bus-off ends. The error-counter arithmetic and the decision to enter bus-off are made elsewhere.

Top module: `can_bor_monitor`

## Requirements
- R1: After reset, recov_done, clr_err_cnt and resume_normal are all 0.
- R2: While armed, every 11 consecutive recessive strobed bits (rx_bit = 1) count one occurrence. The strobe that completes the 128th occurrence produces a recovery pulse in the next cycle.
- R3: A strobed dominant bit (rx_bit = 0) restarts the current recessive run from zero. It leaves the occurrence count unchanged.
- R4: Runs never overlap. After an occurrence is counted, the run restarts from zero, so exactly 11 × 128 = 1408 unbroken recessive bits are needed.
- R5: Cycles with bit_strobe = 0 change no count, whatever rx_bit is.
- R6: recov_done, clr_err_cnt and resume_normal are asserted together, for exactly one cycle per recovery.
- R7: With auto_en = 0 and no host request since bus-off began, no recovery pulse occurs, however many recessive bits arrive.
- R8: A one-cycle host_req during bus-off arms the count. The arm is cleared by the recovery it produces, so a second recovery needs a new request.
- R9: Whenever bus_off is 0, both counts are cleared and any latched host request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_strobe | input | 1 | One-cycle strobe: rx_bit holds a sampled bus bit |
| rx_bit | input | 1 | Sampled bus bit, 1 = recessive |
| bus_off | input | 1 | Node is currently bus-off |
| auto_en | input | 1 | Automatic recovery enable |
| host_req | input | 1 | One-cycle host recovery request |
| recov_done | output | 1 | One-cycle recovery-complete pulse |
| clr_err_cnt | output | 1 | One-cycle command to zero both error counters |
| resume_normal | output | 1 | One-cycle request to return to Normal mode |

## Verification
The assertions assume that bus_off, auto_en and host_req are synchronous to clk, and that reset is held long enough to clear every register. They also assume that bit_strobe stays at 0 or 1 and never goes unknown. The stimulus meets this by changing every input only on the falling clock edge, and by keeping all of them at defined levels from time zero. A behavioural reference model predicts the three outputs on every cycle. Directed phases target dominant interruptions, strobe gaps, the missing arm, the host arm, and a bus-off exit part-way through a count.

// File: rtl/can_bor_pkg.sv
package can_bor_pkg;
  localparam int unsigned RUN_LEN_DEF   = 11;
  localparam int unsigned OCC_TARGET_DEF = 128;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/bor_run_cnt.sv
module bor_run_cnt #(
  parameter int unsigned RUN_LEN = can_bor_pkg::RUN_LEN_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic bit_rec,
  output logic run_done
);
  localparam int unsigned RW = can_bor_pkg::cnt_width(RUN_LEN);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);

  logic [RW-1:0] run_q, run_d;
  logic          run_en;

  always_comb begin
    run_en   = clr | step;
    run_done = 1'b0;
    run_d    = run_q;
    if (clr) begin
      run_d = '0;
    end else if (step) begin
      if (!bit_rec) begin
        run_d = '0;
      end else if (run_q == RUN_LAST) begin
        run_d    = '0;
        run_done = 1'b1;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  // R3: a dominant sample restarts the run
  a_r3_dominant_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !bit_rec && !clr) |=> (run_q == '0));
endmodule

// File: rtl/bor_occ_cnt.sv
module bor_occ_cnt #(
  parameter int unsigned OCC_TARGET = can_bor_pkg::OCC_TARGET_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic target_hit
);
  localparam int unsigned OW = can_bor_pkg::cnt_width(OCC_TARGET);
  localparam logic [OW-1:0] OCC_LAST = OW'(OCC_TARGET - 1);

  logic [OW-1:0] occ_q, occ_d;
  logic          occ_en;

  always_comb begin
    occ_en     = clr | inc;
    target_hit = 1'b0;
    occ_d      = occ_q;
    if (clr) begin
      occ_d = '0;
    end else if (inc) begin
      if (occ_q == OCC_LAST) begin
        occ_d      = '0;
        target_hit = 1'b1;
      end else begin
        occ_d = occ_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (occ_en) occ_q <= occ_d;
  end

  // R9: leaving the armed bus-off state empties the occurrence count
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (occ_q == '0));
endmodule

// File: rtl/bor_arm_ctrl.sv
module bor_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_off,
  input  logic auto_en,
  input  logic host_req,
  input  logic fire,
  output logic armed,
  output logic done_pulse
);
  logic req_q, req_d;
  logic done_q, done_d;

  always_comb begin
    armed = bus_off & (auto_en | req_q | host_req);
    req_d = req_q;
    if (fire)          req_d = 1'b0;
    else if (!bus_off) req_d = 1'b0;
    else if (host_req) req_d = 1'b1;
    done_d = fire & armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      done_q <= done_d;
    end
  end

  assign done_pulse = done_q;

  // R6: recovery pulse lasts one cycle
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: recovery only follows a bus-off cycle
  a_r9_only_in_bus_off: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(bus_off));
  // R7: recovery only follows an armed cycle
  a_r7_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(auto_en || req_q || host_req));
endmodule

// File: rtl/can_bor_monitor.sv
module can_bor_monitor #(
  parameter int unsigned RUN_LEN    = can_bor_pkg::RUN_LEN_DEF,
  parameter int unsigned OCC_TARGET = can_bor_pkg::OCC_TARGET_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_strobe,
  input  logic rx_bit,
  input  logic bus_off,
  input  logic auto_en,
  input  logic host_req,
  output logic recov_done,
  output logic clr_err_cnt,
  output logic resume_normal
);
  logic armed, run_done, target_hit, done_pulse;

  bor_arm_ctrl u_arm (
    .clk(clk), .rst_n(rst_n), .bus_off(bus_off), .auto_en(auto_en),
    .host_req(host_req), .fire(target_hit), .armed(armed),
    .done_pulse(done_pulse)
  );

  bor_run_cnt #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(!armed), .step(bit_strobe),
    .bit_rec(rx_bit), .run_done(run_done)
  );

  bor_occ_cnt #(.OCC_TARGET(OCC_TARGET)) u_occ (
    .clk(clk), .rst_n(rst_n), .clr(!armed), .inc(run_done),
    .target_hit(target_hit)
  );

  assign recov_done    = done_pulse;
  assign clr_err_cnt   = done_pulse;
  assign resume_normal = done_pulse;
endmodule

// File: tb/can_bor_monitor_tb.sv
module can_bor_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RUN = 11;
  localparam int OCC = 128;
  localparam int FULL = RUN * OCC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_strobe = 1'b0, rx_bit = 1'b0, bus_off = 1'b0;
  logic auto_en = 1'b0, host_req = 1'b0;
  logic recov_done, clr_err_cnt, resume_normal;

  int n_checks = 0, n_fail = 0;
  int cycles = 0;
  int pulses = 0, clr_pulses = 0, res_pulses = 0;
  string tag = "R1";
  bit finished = 1'b0;

  // reference model state
  int  m_run = 0, m_occ = 0;
  bit  m_req = 1'b0, exp_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_bor_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .rx_bit(rx_bit),
    .bus_off(bus_off), .auto_en(auto_en), .host_req(host_req),
    .recov_done(recov_done), .clr_err_cnt(clr_err_cnt),
    .resume_normal(resume_normal)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_occ = 0; m_req = 1'b0; exp_done = 1'b0;
    end else begin
      bit armed;
      armed = bus_off && (auto_en || m_req || host_req);
      exp_done = 1'b0;
      if (!bus_off) m_req = 1'b0;
      else if (host_req) m_req = 1'b1;
      if (!armed) begin
        m_run = 0; m_occ = 0;
      end else if (bit_strobe) begin
        if (!rx_bit) m_run = 0;
        else if (m_run == RUN - 1) begin
          m_run = 0;
          m_occ++;
          if (m_occ == OCC) begin
            m_occ = 0; exp_done = 1'b1; m_req = 1'b0;
          end
        end else m_run++;
      end
    end
  end

  task automatic check(input string req, input int act, input int expv, input string what);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      check(tag, recov_done, exp_done, "recov_done vs model");
      check("R6", clr_err_cnt, exp_done, "clr_err_cnt vs model");
      check("R6", resume_normal, exp_done, "resume_normal vs model");
      if (recov_done) pulses++;
      if (clr_err_cnt) clr_pulses++;
      if (resume_normal) res_pulses++;
    end
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic bits(input int n, input bit v, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_strobe = 1'b1; rx_bit = v;
      if (gaps) begin
        @(negedge clk); bit_strobe = 1'b0; rx_bit = ~v;
      end
    end
    @(negedge clk); bit_strobe = 1'b0; rx_bit = 1'b0;
  endtask

  task automatic settle_pulses(input string req, input int expv, input string what);
    repeat (3) @(negedge clk);
    #1;
    check(req, pulses, expv, what);
    pulses = 0; clr_pulses = 0; res_pulses = 0;
  endtask

  task automatic reclear();
    @(negedge clk); bus_off = 1'b0;
    @(negedge clk); bus_off = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", recov_done, 0, "recov_done in reset");
    check("R1", clr_err_cnt, 0, "clr_err_cnt in reset");
    check("R1", resume_normal, 0, "resume_normal in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1", recov_done, 0, "recov_done after reset");

    tag = "R2";
    bus_off = 1'b1; auto_en = 1'b1;
    bits(FULL, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    #1;
    check("R6", clr_pulses, 1, "clr pulse count");
    check("R6", res_pulses, 1, "resume pulse count");
    settle_pulses("R2", 1, "pulses after 128 runs");

    tag = "R3";
    reclear();
    for (int k = 0; k < OCC; k++) begin
      bits(RUN - 1, 1'b1, 1'b0);
      bits(1, 1'b0, 1'b0);
    end
    settle_pulses("R3", 0, "pulses with dominant breaks");
    bits(RUN * (OCC - 1), 1'b1, 1'b0);
    settle_pulses("R3", 0, "pulses one run short");
    bits(RUN, 1'b1, 1'b0);
    settle_pulses("R3", 1, "pulses after final run");

    tag = "R4";
    reclear();
    bits(FULL - 1, 1'b1, 1'b0);
    settle_pulses("R4", 0, "pulses one bit short");
    bits(1, 1'b1, 1'b0);
    settle_pulses("R4", 1, "pulses at exact bit count");

    tag = "R5";
    reclear();
    bits(FULL, 1'b1, 1'b1);
    settle_pulses("R5", 1, "pulses with strobe gaps");

    tag = "R7";
    auto_en = 1'b0;
    reclear();
    bits(2 * FULL, 1'b1, 1'b0);
    settle_pulses("R7", 0, "pulses without arm");

    tag = "R8";
    @(negedge clk); host_req = 1'b1;
    @(negedge clk); host_req = 1'b0;
    bits(FULL, 1'b1, 1'b0);
    settle_pulses("R8", 1, "pulses after host request");
    bits(FULL, 1'b1, 1'b0);
    settle_pulses("R8", 0, "pulses after arm consumed");

    tag = "R9";
    auto_en = 1'b1;
    reclear();
    bits(700, 1'b1, 1'b0);
    reclear();
    bits(FULL - 700, 1'b1, 1'b0);
    settle_pulses("R9", 0, "pulses after bus-off exit");
    bits(700, 1'b1, 1'b0);
    settle_pulses("R9", 1, "pulses after full restart");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule